// File: doc/BRIEF.md
# Used/Dirty-Bit Page Reclaim Scanner

This block tracks a table of physical pages. For each page it keeps three bits: whether the page is currently allocated (valid), whether it has been touched recently (used), and whether it has been written (dirty). A reference port reports every access. An access sets the used bit, and a write also sets the dirty bit. An allocate port hands a page back into service.

Two pointers sweep the table in step, at a fixed distance from each other. The leading sweep pointer clears the used bit of each page it passes. The trailing reclaim pointer arrives at the same page a set number of steps later. If the page is allocated and its used bit is still clear at that point, it has not been touched in the meantime, so the page is reclaimed: its number goes out on the free-page output. If the page was dirty, its number also goes out on the writeback output at the same time.

Both outputs use a valid/ready handshake. The sweep stops for as long as either output holds a page that has not yet been accepted. The distance between the two pointers is taken from a configuration input while reset is asserted.

Top module: `rc_reclaim_scanner`

## Requirements
- R1: While reset is applied and in the first cycle after it, `free_valid` and `wb_valid` are 0, every page is unallocated, and every used and dirty bit is clear.
- R2: A reference sets the used bit of `ref_page` at the next clock edge. If `ref_write` is 1, the same edge also sets the page's dirty bit. A page that is referenced after the sweep pointer has passed it is therefore not reclaimed on the current lap.
- R3: An enabled step is a cycle with `scan_en` high and no stall. On each enabled step, the sweep pointer clears the used bit of its page. In the same step, the reclaim pointer reclaims its page if that page is allocated and its used bit is 0. The reclaimed page number appears on `free_page`, with `free_valid` high, in the cycle after the step.
- R4: A reclaimed page whose dirty bit was set is also presented on `wb_page`, with `wb_valid` high, in the same cycle as the free-page output. A clean reclaimed page raises only `free_valid`.
- R5: The sweep pointer leads the reclaim pointer by `cfg_lag` pages. This value is sampled while reset is low, and a value of 0 is treated as 1. After reset the reclaim pointer is at page 0. Both pointers advance by one page on each enabled step and wrap from page 63 to page 0.
- R6: If a reference to the page under the reclaim pointer arrives in the same cycle as an enabled step, the reference wins and the page is not reclaimed.
- R7: While `free_valid` is high and `free_ready` is low, or `wb_valid` is high and `wb_ready` is low, no step takes place, and the pending page number stays stable on its output.
- R8: An allocate makes `alloc_page` allocated, sets its used bit and clears its dirty bit. This also applies when a reference-write to the same page arrives in the same cycle. An allocate of the page under the reclaim pointer, in the same cycle as a step, prevents its reclaim.
- R9: A reclaimed page becomes unallocated and clean. It is never emitted again until it is re-allocated.
- R10: While `scan_en` is low, both pointers hold and no page is reclaimed. Pending outputs still drain through their handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_lag | input | 6 | Distance from the reclaim pointer to the sweep pointer, sampled during reset |
| scan_en | input | 1 | Allows the pointers to advance |
| ref_valid | input | 1 | A page access is reported this cycle |
| ref_page | input | 6 | Page that was accessed |
| ref_write | input | 1 | The access was a write |
| alloc_valid | input | 1 | A page is (re)allocated this cycle |
| alloc_page | input | 6 | Page being allocated |
| free_ready | input | 1 | Consumer accepts the free-page output |
| free_valid | output | 1 | A reclaimed page number is presented |
| free_page | output | 6 | Reclaimed page number |
| wb_ready | input | 1 | Consumer accepts the writeback output |
| wb_valid | output | 1 | A dirty reclaimed page needs writeback |
| wb_page | output | 6 | Page number to write back |

## Verification
Two events can land in the same cycle: the reclaim decision for the page under the reclaim pointer, and either a reference to that page or an allocate of it.

Directed sequences use a lag of 1 so that a page is cleared in one step and reaches the reclaim point in the next. Reference-at-head and allocate-at-head are each timed to coincide with that second step, and the bench then requires that no free-page output follows.

The random phase steers about a third of all references at the page under the reclaim pointer. A bench model decides each collision by the stated priorities and predicts every output; it runs while the handshake readies toggle at random, so collisions also occur next to stalls.

// File: rtl/rc_pkg.sv
package rc_pkg;

  // Advance a page index by one, wrapping at the table size.
  function automatic int unsigned rc_next(input int unsigned p, input int unsigned n);
    return (p + 1 == n) ? 0 : p + 1;
  endfunction

  // Distance between the pointers; zero is not a usable distance.
  function automatic int unsigned rc_clamp_lag(input int unsigned lag);
    return (lag == 0) ? 1 : lag;
  endfunction

endpackage

// File: rtl/rc_scan_ptrs.sv
module rc_scan_ptrs #(
  parameter int NUM_PAGES = 64,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cfg_lag,
  input  logic              step,
  output logic [PAGE_W-1:0] head_ptr,
  output logic [PAGE_W-1:0] tail_ptr
);
  import rc_pkg::*;

  logic [PAGE_W-1:0] lag_q;
  logic [PAGE_W-1:0] head_q, tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lag_q  <= PAGE_W'(rc_clamp_lag(32'(cfg_lag)));
      head_q <= '0;
      tail_q <= PAGE_W'(rc_clamp_lag(32'(cfg_lag)));
    end else if (step) begin
      head_q <= PAGE_W'(rc_next(32'(head_q), NUM_PAGES));
      tail_q <= PAGE_W'(rc_next(32'(tail_q), NUM_PAGES));
    end
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;

  // R5: the sweep pointer leads by the sampled distance
  assert_ptr_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q == PAGE_W'(32'(head_q) + 32'(lag_q)));

  // R5: one page per enabled step, with wrap
  assert_head_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> head_q == PAGE_W'(rc_next(32'($past(head_q)), NUM_PAGES)));

  // R10: no step, no movement
  assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(head_q));

endmodule

// File: rtl/rc_page_table.sv
module rc_page_table #(
  parameter int NUM_PAGES = 64,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [PAGE_W-1:0] head_ptr,
  input  logic [PAGE_W-1:0] tail_ptr,
  input  logic              ref_valid,
  input  logic [PAGE_W-1:0] ref_page,
  input  logic              ref_write,
  input  logic              alloc_valid,
  input  logic [PAGE_W-1:0] alloc_page,
  output logic              reclaim,
  output logic              reclaim_dirty
);

  logic [NUM_PAGES-1:0] valid_q, used_q, dirty_q;
  logic [NUM_PAGES-1:0] valid_d, used_d, dirty_d;
  logic [NUM_PAGES-1:0] take_vec;
  logic                 ref_hits_head, alloc_hits_head;

  assign ref_hits_head   = ref_valid && (ref_page == head_ptr);
  assign alloc_hits_head = alloc_valid && (alloc_page == head_ptr);

  // Reclaim decision for the page under the trailing pointer.
  assign reclaim = step && valid_q[head_ptr] && !used_q[head_ptr]
                   && !ref_hits_head && !alloc_hits_head;
  assign reclaim_dirty = dirty_q[head_ptr];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    logic is_alloc, is_ref, is_clr, is_take;
    assign is_alloc = alloc_valid && (alloc_page == PAGE_W'(g));
    assign is_ref   = ref_valid && (ref_page == PAGE_W'(g));
    assign is_clr   = step && (tail_ptr == PAGE_W'(g));
    assign is_take  = reclaim && (head_ptr == PAGE_W'(g));
    assign take_vec[g] = is_take;

    always_comb begin
      valid_d[g] = is_alloc ? 1'b1 : (is_take ? 1'b0 : valid_q[g]);
      used_d[g]  = (is_alloc || is_ref) ? 1'b1 : (is_clr ? 1'b0 : used_q[g]);
      if (is_alloc)                dirty_d[g] = 1'b0;
      else if (is_ref && ref_write) dirty_d[g] = 1'b1;
      else if (is_take)            dirty_d[g] = 1'b0;
      else                         dirty_d[g] = dirty_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      used_q  <= used_d;
      dirty_q <= dirty_d;
    end
  end

  // R9: at most one page leaves per cycle
  assert_one_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec));

  // R9: a reclaimed page is unallocated afterwards
  assert_take_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reclaim |=> !valid_q[$past(head_ptr)]);

  // R2: a reference marks the page as used
  assert_ref_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> used_q[$past(ref_page)]);

  // R8: allocate yields an allocated, clean page
  assert_alloc_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> valid_q[$past(alloc_page)] && !dirty_q[$past(alloc_page)]);

endmodule

// File: rtl/rc_emit.sv
module rc_emit #(
  parameter int NUM_PAGES = 64,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              reclaim,
  input  logic              reclaim_dirty,
  input  logic [PAGE_W-1:0] head_ptr,
  input  logic              free_ready,
  input  logic              wb_ready,
  output logic              free_valid,
  output logic [PAGE_W-1:0] free_page,
  output logic              wb_valid,
  output logic [PAGE_W-1:0] wb_page,
  output logic              stall
);

  logic              fv_q, wv_q;
  logic [PAGE_W-1:0] fp_q, wp_q;
  logic              wb_load;

  assign stall   = (fv_q && !free_ready) || (wv_q && !wb_ready);
  assign wb_load = reclaim && reclaim_dirty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_q <= 1'b0;
      wv_q <= 1'b0;
      fp_q <= '0;
      wp_q <= '0;
    end else if (step) begin
      fv_q <= reclaim;
      wv_q <= wb_load;
      if (reclaim) fp_q <= head_ptr;
      if (wb_load) wp_q <= head_ptr;
    end else begin
      if (free_ready) fv_q <= 1'b0;
      if (wb_ready)   wv_q <= 1'b0;
    end
  end

  assign free_valid = fv_q;
  assign free_page  = fp_q;
  assign wb_valid   = wv_q;
  assign wb_page    = wp_q;

  // R7: a refused free-page output is held
  assert_free_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fv_q && !free_ready |=> fv_q && $stable(fp_q));

  // R7: a refused writeback output is held
  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q && !wb_ready |=> wv_q && $stable(wp_q));

  // R4: a dirty reclaim drives both outputs with the same page
  assert_wb_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && wb_load |=> fv_q && wv_q && (wp_q == fp_q));

endmodule

// File: rtl/rc_reclaim_scanner.sv
module rc_reclaim_scanner #(
  parameter int NUM_PAGES = 64,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cfg_lag,
  input  logic              scan_en,
  input  logic              ref_valid,
  input  logic [PAGE_W-1:0] ref_page,
  input  logic              ref_write,
  input  logic              alloc_valid,
  input  logic [PAGE_W-1:0] alloc_page,
  input  logic              free_ready,
  output logic              free_valid,
  output logic [PAGE_W-1:0] free_page,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [PAGE_W-1:0] wb_page
);

  logic              stall, step;
  logic              reclaim, reclaim_dirty;
  logic [PAGE_W-1:0] head_ptr, tail_ptr;

  assign step = scan_en && !stall;

  rc_scan_ptrs #(.NUM_PAGES(NUM_PAGES)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .cfg_lag(cfg_lag), .step(step),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr)
  );

  rc_page_table #(.NUM_PAGES(NUM_PAGES)) u_table (
    .clk(clk), .rst_n(rst_n), .step(step),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .ref_valid(ref_valid), .ref_page(ref_page), .ref_write(ref_write),
    .alloc_valid(alloc_valid), .alloc_page(alloc_page),
    .reclaim(reclaim), .reclaim_dirty(reclaim_dirty)
  );

  rc_emit #(.NUM_PAGES(NUM_PAGES)) u_emit (
    .clk(clk), .rst_n(rst_n), .step(step),
    .reclaim(reclaim), .reclaim_dirty(reclaim_dirty), .head_ptr(head_ptr),
    .free_ready(free_ready), .wb_ready(wb_ready),
    .free_valid(free_valid), .free_page(free_page),
    .wb_valid(wb_valid), .wb_page(wb_page), .stall(stall)
  );

  // R6: a same-cycle reference to the head page blocks its reclaim
  assert_ref_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_page == head_ptr) |-> !reclaim);

  // R3: a reclaim shows up on the free-page port one cycle later
  assert_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reclaim |=> free_valid && free_page == $past(head_ptr));

  // R7: no step while an output is refused
  assert_no_step_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && !free_ready) |-> !step);

endmodule

// File: tb/rc_reclaim_scanner_tb.sv
`timescale 1ns/1ps
module rc_reclaim_scanner_tb;

  localparam int NP = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_lag = 6'd1;
  logic       scan_en = 1'b0;
  logic       ref_valid = 1'b0;
  logic [5:0] ref_page = '0;
  logic       ref_write = 1'b0;
  logic       alloc_valid = 1'b0;
  logic [5:0] alloc_page = '0;
  logic       free_ready = 1'b1;
  logic       wb_ready = 1'b1;
  logic       free_valid, wb_valid;
  logic [5:0] free_page, wb_page;

  always #2 clk = ~clk;

  rc_reclaim_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_lag(cfg_lag), .scan_en(scan_en),
    .ref_valid(ref_valid), .ref_page(ref_page), .ref_write(ref_write),
    .alloc_valid(alloc_valid), .alloc_page(alloc_page),
    .free_ready(free_ready), .free_valid(free_valid), .free_page(free_page),
    .wb_ready(wb_ready), .wb_valid(wb_valid), .wb_page(wb_page)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model
  bit [NP-1:0] m_valid, m_used, m_dirty;
  int m_head, m_tail;
  bit m_fv, m_wv;
  int m_fp, m_wp;

  function automatic int wrap_inc(input int p);
    return (p + 1) % NP;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset(input int lag);
    m_valid = '0; m_used = '0; m_dirty = '0;
    m_head = 0;
    m_tail = (lag == 0) ? 1 : lag;
    m_fv = 0; m_wv = 0; m_fp = 0; m_wp = 0;
  endtask

  task automatic model_step();
    bit stl, stp, take, dty;
    stl  = (m_fv && !free_ready) || (m_wv && !wb_ready);
    stp  = scan_en && !stl;
    take = stp && m_valid[m_head] && !m_used[m_head]
           && !(ref_valid && int'(ref_page) == m_head)
           && !(alloc_valid && int'(alloc_page) == m_head);
    dty  = m_dirty[m_head];
    if (stp) begin
      m_fv = take;
      if (take) m_fp = m_head;
      m_wv = take && dty;
      if (take && dty) m_wp = m_head;
    end else begin
      if (free_ready) m_fv = 0;
      if (wb_ready)   m_wv = 0;
    end
    if (take) begin m_valid[m_head] = 0; m_dirty[m_head] = 0; end
    if (stp) m_used[m_tail] = 0;
    if (ref_valid) begin
      m_used[ref_page] = 1;
      if (ref_write) m_dirty[ref_page] = 1;
    end
    if (alloc_valid) begin
      m_valid[alloc_page] = 1; m_used[alloc_page] = 1; m_dirty[alloc_page] = 0;
    end
    if (stp) begin m_head = wrap_inc(m_head); m_tail = wrap_inc(m_tail); end
  endtask

  task automatic compare_all();
    chk(free_valid == m_fv, "R3 free_valid", int'(free_valid), int'(m_fv));
    if (m_fv && free_valid) chk(int'(free_page) == m_fp, "R3 free_page", int'(free_page), m_fp);
    chk(wb_valid == m_wv, "R4 wb_valid", int'(wb_valid), int'(m_wv));
    if (m_wv && wb_valid) chk(int'(wb_page) == m_wp, "R4 wb_page", int'(wb_page), m_wp);
  endtask

  task automatic idle_inputs();
    scan_en = 0; ref_valid = 0; ref_write = 0; alloc_valid = 0;
    ref_page = '0; alloc_page = '0; free_ready = 1; wb_ready = 1;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    alloc_valid = 0; ref_valid = 0; ref_write = 0;
  endtask

  task automatic do_reset(input int lag);
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    cfg_lag = 6'(lag);
    repeat (2) @(negedge clk);
    chk(free_valid == 0 && wb_valid == 0, "R1 outputs in reset",
        int'(free_valid) + int'(wb_valid), 0);
    rst_n = 1;
    model_reset(lag);
    @(posedge clk);
    @(negedge clk);
    chk(free_valid == 0 && wb_valid == 0, "R1 outputs after reset",
        int'(free_valid) + int'(wb_valid), 0);
  endtask

  task automatic do_alloc(input int p);
    alloc_valid = 1; alloc_page = 6'(p);
    tick();
  endtask

  initial begin
    void'($urandom(32'd7331));
    idle_inputs();

    // R2 R3 R4: dirty page reclaimed on the second step with lag 1
    do_reset(1);
    do_alloc(1);
    ref_valid = 1; ref_page = 6'd1; ref_write = 1;
    tick();
    scan_en = 1;
    tick();
    chk(free_valid == 0, "R3 not yet reclaimed", int'(free_valid), 0);
    tick();
    chk(free_valid == 1 && free_page == 6'd1, "R3 reclaim page 1", int'(free_page), 1);
    chk(wb_valid == 1 && wb_page == 6'd1, "R4 dirty writeback page 1", int'(wb_page), 1);

    // R7: refused free output is held and scanning stops
    free_ready = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(free_valid == 1 && free_page == 6'd1, "R7 held output", int'(free_page), 1);
    end
    free_ready = 1;

    // R9: page 1 never comes back over more than a lap
    begin
      int seen = 0;
      for (int i = 0; i < 70; i++) begin
        tick();
        if (free_valid && free_page == 6'd1) seen++;
      end
      chk(seen == 0, "R9 no second reclaim", seen, 0);
    end

    // R6: reference to the head page in the reclaim cycle wins
    do_reset(1);
    do_alloc(1);
    scan_en = 1;
    tick();
    ref_valid = 1; ref_page = 6'd1;
    tick();
    chk(free_valid == 0, "R6 ref blocks reclaim", int'(free_valid), 0);

    // R2: a page referenced after its sweep survives the lap
    begin
      int seen = 0;
      for (int i = 0; i < 3; i++) begin
        tick();
        if (free_valid) seen++;
      end
      chk(seen == 0, "R2 referenced page kept", seen, 0);
    end

    // R8: allocate of the head page in the reclaim cycle wins
    do_reset(1);
    do_alloc(1);
    scan_en = 1;
    tick();
    alloc_valid = 1; alloc_page = 6'd1;
    tick();
    chk(free_valid == 0, "R8 alloc blocks reclaim", int'(free_valid), 0);

    // R8: allocate clears dirty even with a same-cycle write reference
    do_reset(1);
    alloc_valid = 1; alloc_page = 6'd1;
    ref_valid = 1; ref_page = 6'd1; ref_write = 1;
    tick();
    scan_en = 1;
    tick();
    tick();
    chk(free_valid == 1 && wb_valid == 0, "R8 alloc leaves page clean",
        int'(wb_valid), 0);

    // R5: lag 0 behaves as lag 1; clean page gives no writeback (R4)
    do_reset(0);
    do_alloc(1);
    scan_en = 1;
    tick();
    tick();
    chk(free_valid == 1 && free_page == 6'd1, "R5 lag zero clamped", int'(free_page), 1);
    chk(wb_valid == 0, "R4 clean page no writeback", int'(wb_valid), 0);

    // R5: lag 63 with wrap, page 63 reclaimed on the 64th step
    do_reset(63);
    do_alloc(63);
    scan_en = 1;
    begin
      int first = -1;
      for (int i = 1; i <= 66; i++) begin
        tick();
        if (free_valid && first < 0) first = i;
      end
      chk(first == 64, "R5 wrap timing", first, 64);
    end

    // R10: scan_en low freezes the sweep
    do_reset(1);
    do_alloc(1);
    begin
      int seen = 0;
      for (int i = 0; i < 5; i++) begin
        tick();
        if (free_valid) seen++;
      end
      chk(seen == 0, "R10 idle no reclaim", seen, 0);
    end
    scan_en = 1;
    tick();
    chk(free_valid == 0, "R10 first step clears only", int'(free_valid), 0);
    tick();
    chk(free_valid == 1 && free_page == 6'd1, "R10 reclaim after resume", int'(free_page), 1);

    // Random phase with collisions steered at the head page
    do_reset(1 + int'($urandom % 63));
    for (int i = 0; i < 4000; i++) begin
      scan_en     = ($urandom % 10) < 8;
      free_ready  = ($urandom % 4) != 0;
      wb_ready    = ($urandom % 4) != 0;
      ref_valid   = ($urandom % 10) < 3;
      ref_write   = $urandom % 2;
      ref_page    = (($urandom % 3) == 0) ? 6'(m_head) : 6'($urandom % NP);
      alloc_valid = ($urandom % 5) == 0;
      alloc_page  = (($urandom % 4) == 0) ? 6'(m_head) : 6'($urandom % NP);
      tick();
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule